// File: doc/BRIEF.md
# Amplifier Fault Protection Controller

This block watches six error-detect levels from a speaker power stage and decides whether the stage may play audio. The six levels are over-current, under-voltage, over-voltage, over-temperature, DC offset and clock loss. Each source belongs to one of two classes.

- A latching error stops playback and stays recorded after its detector drops. It is cleared only by a full shutdown cycle followed by a recovery wait.
- A non-latching error pauses playback only while its detector is active. Playback returns on its own when the detector drops.

The stage is held in shutdown whenever either of two run controls is low. One is an active-low pin and the other is a register bit. The block drives three outputs:

- an active-low fault line for an open-drain pad,
- a play-enable level,
- a status vector that a register interface can read.

All detector levels are synchronous to the block clock. The recovery wait is a parameter counted in clock cycles, with a default of 1024.

Top module: `amp_fault_ctl`

## Requirements
- R1: After reset, `play_en_o` is 0, `fault_n_o` is 1 and `err_status_o` is all zero.
- R2: The effective run level is `sd_pin_n` AND `sd_reg_run`. One clock after either input is low, `play_en_o` is 0.
- R3: With no error present, `play_en_o` goes high exactly TIMEOUT+1 rising edges after the first edge that samples both run inputs high. It is still low after TIMEOUT edges.
- R4: If the run level falls before the recovery wait completes, the wait restarts in full on the next rise.
- R5: Status bit positions are fixed: bit 0 over-current, bit 1 under-voltage, bit 2 over-voltage, bit 3 over-temperature, bit 4 DC, bit 5 clock. Bits 0, 3 and 4 are latching. Bits 1, 2 and 5 are non-latching.
- R6: A latching error seen while running drops `play_en_o` one edge after its input is sampled. It sets its status bit and pulls `fault_n_o` low one edge later.
- R7: A latching status bit, the low fault line and the play block all stay in place after the detector input returns low. They clear two edges after the run level is taken low.
- R8: If a latching error is still present when the run level returns high, the status bit sets again and `fault_n_o` goes low. `play_en_o` stays 0 until a further run toggle with the error gone.
- R9: An under-voltage or over-voltage error drops `play_en_o` and shows in its status bit one edge after sampling, while `fault_n_o` stays 1. Both recover one edge after the input clears, with no run toggle.
- R10: A clock error also pulls `fault_n_o` low while present, and releases it one edge after the input clears.
- R11: Latching detector inputs are ignored while the run level is low. No status bit sets and `fault_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sd_pin_n | input | 1 | Run control from the pin (0 = shutdown) |
| sd_reg_run | input | 1 | Run control from the register bit (0 = shutdown) |
| err_i | input | 6 | Detector levels, one bit per source in the R5 order |
| fault_n_o | output | 1 | Active-low fault drive for the open-drain pad (0 = pull low) |
| play_en_o | output | 1 | Power stage may play audio |
| err_status_o | output | 6 | Status vector: latching bits held, non-latching bits live |

## Verification
The bench probes the edges of the recovery wait by sampling one cycle before and at the cycle of release. A counter that is off by one would enable playback a cycle early or late. It cuts the wait short and retries it, which catches a timer that resumes from its partial count instead of restarting. It releases shutdown while a latching detector is still high, which exposes a design that plays for a cycle or never re-latches. It also applies latching errors during shutdown and confirms that none is recorded. It runs every source individually, so a wrong class assignment (for example a clock error that does not pull the pin low, or an under-voltage that latches) shows up as a status bit or fault line in the wrong state.

// File: rtl/afp_pkg.sv
package afp_pkg;
  localparam int unsigned NSRC = 6;

  localparam int unsigned IDX_OC  = 0;
  localparam int unsigned IDX_UV  = 1;
  localparam int unsigned IDX_OV  = 2;
  localparam int unsigned IDX_OT  = 3;
  localparam int unsigned IDX_DC  = 4;
  localparam int unsigned IDX_CLK = 5;

  // sources that stay recorded until a shutdown cycle
  localparam logic [NSRC-1:0] LATCH_MASK = (NSRC'(1) << IDX_OC)
                                         | (NSRC'(1) << IDX_OT)
                                         | (NSRC'(1) << IDX_DC);
  // non-latching sources that still drive the fault pad
  localparam logic [NSRC-1:0] PAD_NL_MASK = (NSRC'(1) << IDX_CLK);
endpackage

// File: rtl/afp_run_ctl.sv
module afp_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_pin_n,
  input  logic sd_reg_run,
  output logic run_o
);
  logic run_q, run_nx;

  always_comb begin
    run_nx = sd_pin_n & sd_reg_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_nx;
  end

  assign run_o = run_q;
endmodule

// File: rtl/afp_recover_timer.sv
module afp_recover_timer #(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          rdy_q, rdy_nx;
  logic          cnt_en;

  assign cnt_en = run_i & ~rdy_q;

  always_comb begin
    cnt_nx = cnt_q;
    rdy_nx = rdy_q;
    if (!run_i) begin
      cnt_nx = '0;
      rdy_nx = 1'b0;
    end else if (cnt_en) begin
      cnt_nx = cnt_q + CW'(1);
      if (cnt_q == LAST) rdy_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      rdy_q <= rdy_nx;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/afp_err_track.sv
module afp_err_track
  import afp_pkg::*;
#(
  parameter int unsigned N = NSRC,
  parameter logic [N-1:0] LMASK = LATCH_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [N-1:0] err_i,
  output logic [N-1:0] live_o,
  output logic [N-1:0] held_o
);
  logic [N-1:0] live_q;
  logic [N-1:0] held_q, held_nx;

  for (genvar g = 0; g < int'(N); g++) begin : g_src
    if (LMASK[g]) begin : g_latch
      assign held_nx[g] = run_i & (held_q[g] | live_q[g]);
    end else begin : g_live
      assign held_nx[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      held_q <= '0;
    end else begin
      live_q <= err_i;
      held_q <= held_nx;
    end
  end

  assign live_o = live_q;
  assign held_o = held_q;
endmodule

// File: rtl/amp_fault_ctl.sv
module amp_fault_ctl
  import afp_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sd_pin_n,
  input  logic            sd_reg_run,
  input  logic [NSRC-1:0] err_i,
  output logic            fault_n_o,
  output logic            play_en_o,
  output logic [NSRC-1:0] err_status_o
);
  logic            run_q;
  logic            ready;
  logic [NSRC-1:0] live;
  logic [NSRC-1:0] held;

  afp_run_ctl u_run (
    .clk(clk), .rst_n(rst_n),
    .sd_pin_n(sd_pin_n), .sd_reg_run(sd_reg_run),
    .run_o(run_q)
  );

  afp_recover_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .ready_o(ready)
  );

  afp_err_track #(.N(NSRC), .LMASK(LATCH_MASK)) u_trk (
    .clk(clk), .rst_n(rst_n), .run_i(run_q),
    .err_i(err_i), .live_o(live), .held_o(held)
  );

  assign err_status_o = held | (live & ~LATCH_MASK);
  assign fault_n_o    = ~(|held | |(live & PAD_NL_MASK));
  assign play_en_o    = run_q & ready & ~|held & ~|live;
endmodule

// File: rtl/afp_checker.sv
module afp_checker
  import afp_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sd_pin_n,
  input logic            sd_reg_run,
  input logic [NSRC-1:0] err_i,
  input logic            run_q,
  input logic            fault_n_o,
  input logic            play_en_o,
  input logic [NSRC-1:0] err_status_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1) + 1;
  logic [CW-1:0] up_cnt;
  logic [NSRC-1:0] lat;

  assign lat = err_status_o & LATCH_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  up_cnt <= '0;
    else if (!run_q)             up_cnt <= '0;
    else if (up_cnt < CW'(TIMEOUT)) up_cnt <= up_cnt + CW'(1);
  end

  // R2
  play_off_in_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_pin_n && sd_reg_run) |=> !play_en_o);

  // R3
  wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_en_o |-> (up_cnt >= CW'(TIMEOUT)));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ((lat & $past(lat)) == $past(lat)));

  // R9
  nl_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_i & ~LATCH_MASK) != '0) |=> !play_en_o);

  // R10
  clk_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_i[IDX_CLK] |=> !fault_n_o);

  // R6
  pad_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n_o |-> ((lat != '0) || err_status_o[IDX_CLK]));
endmodule

bind amp_fault_ctl afp_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_pin_n(sd_pin_n), .sd_reg_run(sd_reg_run),
  .err_i(err_i), .run_q(run_q), .fault_n_o(fault_n_o),
  .play_en_o(play_en_o), .err_status_o(err_status_o)
);

// File: tb/sim_amp_fault_ctl.sv
module sim_amp_fault_ctl;
  localparam int unsigned TO = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sd_pin_n, sd_reg_run;
  logic [5:0] err_i;
  logic       fault_n_o, play_en_o;
  logic [5:0] err_status_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  amp_fault_ctl #(.TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .sd_pin_n(sd_pin_n), .sd_reg_run(sd_reg_run),
    .err_i(err_i), .fault_n_o(fault_n_o), .play_en_o(play_en_o),
    .err_status_o(err_status_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go_run();
    sd_pin_n = 1'b1; sd_reg_run = 1'b1;
    tick(TO);
    chk("R3 play still low after TIMEOUT edges", play_en_o, 0);
    tick(1);
    chk("R3 play high after TIMEOUT+1 edges", play_en_o, 1);
  endtask

  task automatic t_reset();
    chk("R1 play after reset", play_en_o, 0);
    chk("R1 fault after reset", fault_n_o, 1);
    chk("R1 status after reset", err_status_o, 0);
  endtask

  task automatic t_reg_bit();
    go_run();
    sd_reg_run = 1'b0;
    tick(1);
    chk("R2 register bit holds shutdown", play_en_o, 0);
    sd_reg_run = 1'b1; sd_pin_n = 1'b0;
    tick(1);
    chk("R2 pin holds shutdown", play_en_o, 0);
    go_run();
  endtask

  task automatic t_restart();
    sd_pin_n = 1'b0; tick(2);
    sd_pin_n = 1'b1; tick(8);
    chk("R4 play low mid wait", play_en_o, 0);
    sd_pin_n = 1'b0; tick(2);
    sd_pin_n = 1'b1;
    tick(TO);
    chk("R4 wait restarted in full", play_en_o, 0);
    tick(1);
    chk("R4 play after full restart", play_en_o, 1);
  endtask

  task automatic t_latch(input int b);
    err_i = 6'(1 << b);
    tick(1);
    chk($sformatf("R6 play drops bit%0d", b), play_en_o, 0);
    tick(1);
    chk($sformatf("R5 R6 status bit%0d", b), err_status_o, 6'(1 << b));
    chk($sformatf("R6 fault low bit%0d", b), fault_n_o, 0);
    err_i = '0;
    tick(3);
    chk($sformatf("R7 status held bit%0d", b), err_status_o, 6'(1 << b));
    chk($sformatf("R7 fault held bit%0d", b), fault_n_o, 0);
    chk($sformatf("R7 play blocked bit%0d", b), play_en_o, 0);
    sd_pin_n = 1'b0;
    tick(2);
    chk($sformatf("R7 status cleared bit%0d", b), err_status_o, 0);
    chk($sformatf("R7 fault released bit%0d", b), fault_n_o, 1);
    go_run();
  endtask

  task automatic t_retry();
    err_i = 6'b001000;
    tick(2);
    chk("R8 first latch", err_status_o, 6'b001000);
    sd_reg_run = 1'b0; tick(2);
    sd_reg_run = 1'b1; tick(2);
    chk("R8 relatched status", err_status_o, 6'b001000);
    chk("R8 relatched fault", fault_n_o, 0);
    tick(TO + 2);
    chk("R8 play stays off", play_en_o, 0);
    err_i = '0;
    sd_reg_run = 1'b0; tick(2);
    go_run();
  endtask

  task automatic t_nonlatch(input int b);
    err_i = 6'(1 << b);
    tick(1);
    chk($sformatf("R9 R5 live status bit%0d", b), err_status_o, 6'(1 << b));
    chk($sformatf("R9 play paused bit%0d", b), play_en_o, 0);
    chk($sformatf("R9 fault untouched bit%0d", b), fault_n_o, 1);
    err_i = '0;
    tick(1);
    chk($sformatf("R9 status cleared bit%0d", b), err_status_o, 0);
    chk($sformatf("R9 play resumes bit%0d", b), play_en_o, 1);
  endtask

  task automatic t_clock();
    err_i = 6'b100000;
    tick(1);
    chk("R10 fault low on clock error", fault_n_o, 0);
    chk("R10 R5 clock status", err_status_o, 6'b100000);
    tick(5);
    chk("R10 fault held while present", fault_n_o, 0);
    chk("R10 play paused", play_en_o, 0);
    err_i = '0;
    tick(1);
    chk("R10 fault released", fault_n_o, 1);
    chk("R10 play resumes", play_en_o, 1);
  endtask

  task automatic t_ignore_in_sd();
    sd_pin_n = 1'b0; tick(2);
    err_i = 6'b011001;
    tick(3);
    chk("R11 no status during shutdown", err_status_o, 0);
    chk("R11 fault idle during shutdown", fault_n_o, 1);
    err_i = '0; tick(1);
    go_run();
    chk("R11 no late latch", err_status_o, 0);
  endtask

  initial begin
    #5_000_000;
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sd_pin_n = 1'b0; sd_reg_run = 1'b0; err_i = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_reg_bit();
    t_restart();
    t_latch(0);
    t_latch(3);
    t_latch(4);
    t_retry();
    t_nonlatch(1);
    t_nonlatch(2);
    t_clock();
    t_ignore_in_sd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule